// File: doc/BRIEF.md
# Dual-clock width-packing port write buffer

This buffer sits on one port of a multi-port memory controller. It carries write data from a client clock domain into the controller clock domain. The client presents narrow words with a write enable. It stalls only while the buffer reports full. The buffer packs consecutive client words into one wide controller word and stores the result in a small dual-port memory.

The controller side sees three things: the oldest wide word, an empty flag and an almost-full flag. The arbiter treats almost-full as a burst-ready request. It then asserts the read enable and streams entries out at its own clock. The two sides run independently. Pointers cross between the clocks as Gray codes through two-flop synchronizers.

The packer is a two-state machine. In `PK_IDLE` the next accepted word goes into lane 0, and acceptance moves the machine to `PK_FILL`. In `PK_FILL` accepted words go into the next lanes. Acceptance of the word for the top lane commits the whole entry and returns the machine to `PK_IDLE`. When the client width equals the controller width, a single-lane variant commits every accepted word and has no state register.

Top module: `port_wbuf`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `almost_full` is 0.
- R2: With CW=32 and WW=128, four accepted client words w0, w1, w2, w3 come out as one `rd_data` equal to {w3, w2, w1, w0}. The first word occupies bits 31:0.
- R3: An entry whose top lane has not yet been accepted is not visible to the read side. `empty` stays 1 after three of four words and falls only after the fourth word has crossed the clock boundary.
- R4: `full` is 1 while DEPTH committed entries are stored, as seen from the write clock. A `wr_en` pulse while `full` is 1 has no effect: the word is captured into no lane and no entry.
- R5: `almost_full` is 1 exactly when the stored entry count seen from the write clock is at least AF_LEVEL. Whenever `full` is 1, `almost_full` is also 1.
- R6: While `empty` is 0, `rd_data` shows the oldest stored entry, and `rd_en` removes it. Entries leave in the order they were committed. `rd_en` while `empty` is 1 has no effect.
- R7: Pops and pushes in the two independent clocks may overlap freely. After a pop, `full` falls once the freed slot has crossed to the write clock. No entry is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Client clock |
| wrst_n | input | 1 | Client-domain asynchronous reset, active low |
| wr_en | input | 1 | Client word valid; accepted when `full` is 0 |
| wr_data | input | CW | Client word |
| full | output | 1 | No space; client must hold and retry |
| almost_full | output | 1 | At least AF_LEVEL entries stored; burst ready |
| rclk | input | 1 | Controller clock |
| rrst_n | input | 1 | Controller-domain asynchronous reset, active low |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | WW | Oldest stored entry |
| empty | output | 1 | No committed entry visible to the read side |

## Verification
Two functions can fall into the same instant. The first pair is a commit from the client side and a pop from the controller side. A writer and a reader run concurrently for 24 entries on clocks of 12 ns and 8 ns, and every popped word is compared with an arithmetic model of the packing. The second pair is a full buffer and a drain. The buffer is filled, writes are attempted while full, one entry is drained, and the bench then checks that `full` clears and that none of the blocked words appears in the stream. A sweep of every fill level from 1 to DEPTH compares `almost_full` and `full` against the count.

// File: rtl/port_wbuf_pkg.sv
package port_wbuf_pkg;
    typedef enum logic {
        PK_IDLE = 1'b0,
        PK_FILL = 1'b1
    } pk_state_e;
endpackage

// File: rtl/gray_ptr.sv
module gray_ptr #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [PW-1:0] bin_q,
    output logic [PW-1:0] gray_q
);
    logic [PW-1:0] bin_next;

    always_comb begin
        bin_next = bin_q + {{(PW-1){1'b0}}, inc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_next;
            gray_q <= bin_next ^ (bin_next >> 1);
        end
    end
endmodule

// File: rtl/sync_2ff.sv
module sync_2ff #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dp_store.sv
module dp_store #(
    parameter int DEPTH = 8,
    parameter int WW    = 128,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lane_packer.sv
module lane_packer
    import port_wbuf_pkg::*;
#(
    parameter int CW  = 32,
    parameter int WW  = 128,
    localparam int LANES = WW / CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [CW-1:0] in_data,
    output logic          commit,
    output logic [WW-1:0] commit_data
);
    generate
        if (LANES > 1) begin : g_multi
            localparam int LW = $clog2(LANES);

            pk_state_e     state_q, state_d;
            logic [LW-1:0] lane_q;
            logic [WW-1:0] pack_q;
            logic          last_lane;

            assign last_lane = (lane_q == LW'(LANES - 1));

            // state register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= PK_IDLE;
                end else begin
                    state_q <= state_d;
                end
            end

            // next state and outputs
            always_comb begin
                state_d     = state_q;
                commit      = 1'b0;
                commit_data = pack_q;
                commit_data[(LANES-1)*CW +: CW] = in_data;
                unique case (state_q)
                    PK_IDLE: begin
                        if (accept) begin
                            state_d = PK_FILL;
                        end
                    end
                    PK_FILL: begin
                        if (accept && last_lane) begin
                            commit  = 1'b1;
                            state_d = PK_IDLE;
                        end
                    end
                    default: state_d = PK_IDLE;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= '0;
                    pack_q <= '0;
                end else if (accept) begin
                    pack_q[lane_q*CW +: CW] <= in_data;
                    lane_q <= last_lane ? '0 : lane_q + 1'b1;
                end
            end
        end else begin : g_single
            assign commit      = accept;
            assign commit_data = in_data;
        end
    endgenerate
endmodule

// File: rtl/port_wbuf.sv
module port_wbuf #(
    parameter int CW       = 32,
    parameter int WW       = 128,
    parameter int DEPTH    = 8,
    parameter int AF_LEVEL = 4
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic          full,
    output logic          almost_full,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    output logic [WW-1:0] rd_data,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // write domain
    logic          accept;
    logic          commit;
    logic [WW-1:0] commit_data;
    logic [PW-1:0] wr_bin, wr_gray;
    logic [PW-1:0] rd_gray_w;
    logic [PW-1:0] wr_count;

    // read domain
    logic          pop;
    logic [PW-1:0] rd_bin, rd_gray;
    logic [PW-1:0] wr_gray_r;

    assign accept = wr_en && !full;

    lane_packer #(.CW(CW), .WW(WW)) u_pack (
        .clk         (wclk),
        .rst_n       (wrst_n),
        .accept      (accept),
        .in_data     (wr_data),
        .commit      (commit),
        .commit_data (commit_data)
    );

    gray_ptr #(.PW(PW)) u_wptr (
        .clk    (wclk),
        .rst_n  (wrst_n),
        .inc    (commit),
        .bin_q  (wr_bin),
        .gray_q (wr_gray)
    );

    sync_2ff #(.W(PW)) u_rsync (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rd_gray),
        .q     (rd_gray_w)
    );

    assign wr_count    = wr_bin - gray_to_bin(rd_gray_w);
    assign full        = (wr_count == PW'(DEPTH));
    assign almost_full = (wr_count >= PW'(AF_LEVEL));

    dp_store #(.DEPTH(DEPTH), .WW(WW)) u_mem (
        .wclk  (wclk),
        .we    (commit),
        .waddr (wr_bin[AW-1:0]),
        .wdata (commit_data),
        .raddr (rd_bin[AW-1:0]),
        .rdata (rd_data)
    );

    sync_2ff #(.W(PW)) u_wsync (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wr_gray),
        .q     (wr_gray_r)
    );

    assign empty = (rd_gray == wr_gray_r);
    assign pop   = rd_en && !empty;

    gray_ptr #(.PW(PW)) u_rptr (
        .clk    (rclk),
        .rst_n  (rrst_n),
        .inc    (pop),
        .bin_q  (rd_bin),
        .gray_q (rd_gray)
    );
endmodule

// File: rtl/port_wbuf_chk.sv
module port_wbuf_chk #(
    parameter int DEPTH = 8,
    localparam int PW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
    input logic          wclk,
    input logic          wrst_n,
    input logic          rclk,
    input logic          rrst_n,
    input logic          full,
    input logic          almost_full,
    input logic          empty,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr
);
    always @(posedge rclk) begin
        if (!rrst_n) begin
            AST_RESET_EMPTY: assert (empty); // R1
        end
    end

    AST_FULL_HAS_AF: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |-> almost_full); // R5

    AST_FULL_FREEZE: assert property (@(posedge wclk) disable iff (!wrst_n)
        full |=> $stable(wr_ptr)); // R4

    AST_EMPTY_FREEZE: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |=> $stable(rd_ptr)); // R6

    AST_COMMIT_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
        1'b1 |=> (wr_ptr == $past(wr_ptr)) || (wr_ptr == $past(wr_ptr) + PW'(1))); // R3
endmodule

bind port_wbuf port_wbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .wclk        (wclk),
    .wrst_n      (wrst_n),
    .rclk        (rclk),
    .rrst_n      (rrst_n),
    .full        (full),
    .almost_full (almost_full),
    .empty       (empty),
    .wr_ptr      (wr_bin),
    .rd_ptr      (rd_bin)
);

// File: tb/test_port_wbuf.sv
`timescale 1ns/1ps
module test_port_wbuf;
    localparam int CW = 32, WW = 128, DEPTH = 8, AF = 4, LANES = WW / CW;

    logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [CW-1:0] wr_data = '0;
    logic full, almost_full, empty;
    logic [WW-1:0] rd_data;

    int n_tests = 0, n_fail = 0;
    logic [WW-1:0] model [64];
    int head = 0, tail = 0;

    always #6 wclk = ~wclk;   // client clock
    always #4 rclk = ~rclk;   // controller clock, 125 MHz

    port_wbuf #(.CW(CW), .WW(WW), .DEPTH(DEPTH), .AF_LEVEL(AF)) i_port_wbuf (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .almost_full(almost_full),
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty)
    );

    function automatic logic [CW-1:0] word_of(int k, int lane);
        return {8'h5A, 8'(lane), 16'(k)};
    endfunction

    function automatic logic [WW-1:0] entry_of(int k);
        logic [WW-1:0] e;
        for (int l = 0; l < LANES; l++) e[l*CW +: CW] = word_of(k, l);
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_word(input logic [CW-1:0] d);
        @(negedge wclk);
        while (full) @(negedge wclk);
        wr_en = 1; wr_data = d;
        @(posedge wclk); #1 wr_en = 0;
    endtask

    task automatic push_entry(input int k);
        for (int l = 0; l < LANES; l++) push_word(word_of(k, l));
        model[tail % 64] = entry_of(k);
        tail++;
    endtask

    task automatic pop_check(input string tag);
        @(negedge rclk);
        while (empty) @(negedge rclk);
        chk(rd_data == model[head % 64], tag, rd_data, model[head % 64]);
        rd_en = 1;
        @(posedge rclk); #1 rd_en = 0;
        head++;
    endtask

    task automatic settle();
        repeat (8) @(posedge wclk);
        @(negedge rclk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (4) @(posedge wclk);
        @(negedge wclk) wrst_n = 1;
        @(negedge rclk) rrst_n = 1;
        settle();
        // R1 reset state
        chk(empty == 1, "R1 empty", WW'(empty), 1);
        chk(full == 0, "R1 full", WW'(full), 0);
        chk(almost_full == 0, "R1 almost_full", WW'(almost_full), 0);

        // R3 partial entry stays hidden
        for (int l = 0; l < LANES - 1; l++) push_word(word_of(7, l));
        settle();
        chk(empty == 1, "R3 partial hidden", WW'(empty), 1);
        push_word(word_of(7, LANES - 1));
        model[tail % 64] = entry_of(7); tail++;
        settle();
        chk(empty == 0, "R3 visible after last lane", WW'(empty), 0);
        pop_check("R2 packing order");
        settle();
        chk(empty == 1, "R6 empty after drain", WW'(empty), 1);

        // R4/R5 sweep of every fill level
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) push_entry(n * 16 + k);
            settle();
            chk(almost_full == (n >= AF), "R5 almost_full level", WW'(almost_full), WW'(n >= AF));
            chk(full == (n == DEPTH), "R4 full level", WW'(full), WW'(n == DEPTH));
            for (int k = 0; k < n; k++) pop_check("R6 order in sweep");
            settle();
            chk(empty == 1 && almost_full == 0, "R5 clear after drain", WW'({empty, almost_full}), 2);
        end

        // R4 writes while full are dropped; R7 full clears after a pop
        for (int k = 0; k < DEPTH; k++) push_entry(300 + k);
        settle();
        chk(full == 1, "R4 full reached", WW'(full), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge wclk); wr_en = 1; wr_data = 32'hDEAD_0000 + 32'(i);
            @(posedge wclk); #1 wr_en = 0;
        end
        chk(full == 1, "R4 still full", WW'(full), 1);
        pop_check("R6 first after full");
        settle();
        chk(full == 0, "R7 full clears after pop", WW'(full), 0);
        push_entry(399);
        settle();
        for (int k = 0; k < DEPTH; k++) pop_check("R4 no blocked word stored");
        settle();
        chk(empty == 1, "R4 drained", WW'(empty), 1);

        // R6 rd_en while empty ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge rclk) rd_en = 1;
            @(posedge rclk); #1 rd_en = 0;
        end
        push_entry(500);
        settle();
        pop_check("R6 pop on empty ignored");
        settle();
        chk(empty == 1, "R6 single entry drained", WW'(empty), 1);

        // R7 concurrent push and pop
        fork
            for (int k = 0; k < 24; k++) push_entry(600 + k);
            for (int k = 0; k < 24; k++) pop_check("R7 concurrent stream");
        join
        settle();
        chk(empty == 1 && full == 0, "R7 end state", WW'({empty, full}), 2);

        summary();
    end
endmodule